// File: doc/BRIEF.md
# Incremental Converter Sequencer

This block is the digital half of a first-order incremental analog-to-digital converter. An external modulator integrates the analog input and returns a one-bit density stream. The sequencer opens a conversion window of a fixed number of clock cycles. During the window it counts the cycles on which the density bit is high. When the window closes, it raises the integrator-clear line for one cycle, stores the count as the new sample and flags it with a one-cycle strobe.

The window length sets the resolution. A narrow setting uses 256 cycles and gives an 8-bit result. A wide setting uses 4096 cycles and gives a 12-bit result. Each extra bit doubles the window, so the sample rate falls by half. At 1 MHz the rate is about 3.9 kS/s in narrow mode and about 244 S/s in wide mode.

The resolution select is sampled only in the clear cycle, so a window that has already started runs to its original length. The clear line stays high while the block is in reset, so the integrator starts each conversion from zero.

Top module: `incadc_ctrl`

## Requirements
- R1: While `rst_n` is low, `int_clr_o` is 1, `smp_vld_o` is 0 and `smp_o` is 0.
- R2: `int_clr_o` is high for exactly one cycle between windows. It stays low for exactly 2^N cycles per window, where N is 8 when `res_wide_i` is 0 and 12 when it is 1.
- R3: `smp_vld_o` is high for one cycle, only during a clear cycle that ends a window, and never inside a window.
- R4: The sample equals the number of cycles within the window on which `dens_i` was high. For a first-order density stream it is within one LSB of the input level scaled to 2^N.
- R5: A density bit that is high for a whole window produces the saturated code 2^N-1: 255 in narrow mode and 4095 in wide mode. Narrow-mode samples never set bits 11..8.
- R6: `dens_i` has no effect during the clear cycle; the count starts from zero in every window.
- R7: `res_wide_i` is sampled only in the clear cycle. A change inside a window takes effect from the next window onward.
- R8: `smp_o` holds its value between valid strobes.
- R9: A density bit that stays low for a whole window produces a sample of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dens_i | input | 1 | Density bit from the modulator |
| res_wide_i | input | 1 | Resolution select: 0 = 8-bit window, 1 = 12-bit window |
| int_clr_o | output | 1 | Integrator clear, high between windows |
| smp_o | output | 12 | Latest sample, zero-extended in narrow mode |
| smp_vld_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench sets the density bit high during every clear cycle. A design that let the tally run in that cycle would report one count too many. A counter only N bits wide would wrap to 0 when the density stream is all ones, instead of saturating at 2^N-1.

The bench flips the resolution select part-way through both a narrow window and a wide window. A design that reacted at once would close the window at the wrong length or apply the wrong saturation code. The bench also covers an all-zero stream and several intermediate levels. These expose an off-by-one in the window length, which would make the sample disagree with the bench's own count of the density bits it drove.

// File: rtl/incadc_pkg.sv
// Package: incadc_pkg
// Shared types for the incremental converter sequencer.
package incadc_pkg;

    // Resolution modes; the encoding matches the res_wide_i pin.
    typedef enum logic {
        RES_NARROW = 1'b0,
        RES_WIDE   = 1'b1
    } res_mode_e;

endpackage

// File: rtl/incadc_window.sv
// Module: incadc_window
// Sequences one-cycle clear phases and fixed-length conversion windows.
// Assumes: the resolution select is sampled only in the clear phase. The
// window length is 2^LO_BITS or 2^HI_BITS cycles, and HI_BITS > LO_BITS.
module incadc_window
    import incadc_pkg::*;
#(
    parameter int unsigned LO_BITS = 8,
    parameter int unsigned HI_BITS = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      res_wide_i,
    output logic      clr_o,
    output logic      last_o,
    output res_mode_e mode_o
);

    localparam logic [HI_BITS-1:0] LO_LAST = {{(HI_BITS-LO_BITS){1'b0}}, {LO_BITS{1'b1}}};
    localparam logic [HI_BITS-1:0] HI_LAST = {HI_BITS{1'b1}};

    logic [HI_BITS-1:0] pos_q;
    logic [HI_BITS-1:0] limit;
    logic               clr_q;
    res_mode_e          mode_q;

    // Purpose: choose the final window position for the latched mode.
    always_comb begin
        limit = (mode_q == RES_WIDE) ? HI_LAST : LO_LAST;
    end

    assign last_o = !clr_q && (pos_q == limit);
    assign clr_o  = clr_q;
    assign mode_o = mode_q;

    // Purpose: step through the clear phase, then the window positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q  <= 1'b1;
            pos_q  <= '0;
            mode_q <= RES_NARROW;
        end else if (clr_q) begin
            clr_q  <= 1'b0;
            pos_q  <= '0;
            mode_q <= res_mode_e'(res_wide_i);
        end else if (last_o) begin
            clr_q  <= 1'b1;
        end else begin
            pos_q  <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/incadc_tally.sv
// Module: incadc_tally
// Counts the cycles on which the density bit is high.
// Assumes: clear_i is high only in the clear phase. The tally is one bit
// wider than HI_BITS, so a full window of ones cannot wrap.
module incadc_tally #(
    parameter int unsigned HI_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             dens_i,
    output logic [HI_BITS:0] sum_o
);

    logic [HI_BITS:0] tally_q;

    // Purpose: the running total, including the current cycle's density bit.
    always_comb begin
        sum_o = tally_q + {{HI_BITS{1'b0}}, dens_i};
    end

    // Purpose: clear in the clear phase, otherwise accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else if (clear_i) begin
            tally_q <= '0;
        end else begin
            tally_q <= sum_o;
        end
    end

endmodule

// File: rtl/incadc_capture.sv
// Module: incadc_capture
// Stores the saturated window total and raises the valid strobe.
// Assumes: take_i is high for one cycle, on the last cycle of a window.
module incadc_capture
    import incadc_pkg::*;
#(
    parameter int unsigned LO_BITS = 8,
    parameter int unsigned HI_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  res_mode_e          mode_i,
    input  logic [HI_BITS:0]   sum_i,
    output logic [HI_BITS-1:0] sample_o,
    output logic               valid_o
);

    localparam logic [HI_BITS:0] LO_CAP = {{(HI_BITS+1-LO_BITS){1'b0}}, {LO_BITS{1'b1}}};
    localparam logic [HI_BITS:0] HI_CAP = {1'b0, {HI_BITS{1'b1}}};

    logic [HI_BITS:0] cap;
    logic [HI_BITS:0] clipped;

    // Purpose: clip a full-window total to the largest code of the mode.
    always_comb begin
        cap     = (mode_i == RES_WIDE) ? HI_CAP : LO_CAP;
        clipped = (sum_i > cap) ? cap : sum_i;
    end

    // Purpose: register the sample and the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= take_i;
            if (take_i) begin
                sample_o <= clipped[HI_BITS-1:0];
            end
        end
    end

endmodule

// File: rtl/incadc_ctrl.sv
// Module: incadc_ctrl
// Top level of the incremental converter sequencer.
// Assumes: dens_i is synchronous to clk. The analog integrator is cleared
// while int_clr_o is high.
module incadc_ctrl
    import incadc_pkg::*;
#(
    parameter int unsigned LO_BITS = 8,
    parameter int unsigned HI_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dens_i,
    input  logic               res_wide_i,
    output logic               int_clr_o,
    output logic [HI_BITS-1:0] smp_o,
    output logic               smp_vld_o
);

    logic             clr_w;
    logic             last_w;
    res_mode_e        mode_w;
    logic [HI_BITS:0] sum_w;

    incadc_window #(.LO_BITS(LO_BITS), .HI_BITS(HI_BITS)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_wide_i (res_wide_i),
        .clr_o      (clr_w),
        .last_o     (last_w),
        .mode_o     (mode_w)
    );

    incadc_tally #(.HI_BITS(HI_BITS)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr_w),
        .dens_i  (dens_i),
        .sum_o   (sum_w)
    );

    incadc_capture #(.LO_BITS(LO_BITS), .HI_BITS(HI_BITS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (last_w),
        .mode_i   (mode_w),
        .sum_i    (sum_w),
        .sample_o (smp_o),
        .valid_o  (smp_vld_o)
    );

    assign int_clr_o = clr_w;

endmodule

// File: rtl/incadc_ctrl_chk.sv
// Module: incadc_ctrl_chk
// Protocol checker for incadc_ctrl, attached to it with the bind below.
module incadc_ctrl_chk #(
    parameter int unsigned LO_BITS = 8,
    parameter int unsigned HI_BITS = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               int_clr,
    input logic               vld,
    input logic [HI_BITS-1:0] smp,
    input logic               mode
);

    localparam logic [HI_BITS:0] LO_SPAN = (HI_BITS+1)'(1) << LO_BITS;
    localparam logic [HI_BITS:0] HI_SPAN = (HI_BITS+1)'(1) << HI_BITS;

    logic [HI_BITS:0] run_q;

    // Purpose: count the consecutive cycles with the clear line low.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (int_clr) run_q <= '0;
        else              run_q <= run_q + 1'b1;
    end

    // R2
    clear_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr |=> !int_clr);

    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && run_q != '0) |-> (run_q == (mode ? HI_SPAN : LO_SPAN)));

    // R3
    valid_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> int_clr);

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    // R8
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smp) |-> vld);

    // R5
    narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !mode) |-> (smp[HI_BITS-1:LO_BITS] == '0));

endmodule

bind incadc_ctrl incadc_ctrl_chk #(.LO_BITS(LO_BITS), .HI_BITS(HI_BITS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .int_clr (int_clr_o),
    .vld     (smp_vld_o),
    .smp     (smp_o),
    .mode    (mode_w)
);

// File: tb/incadc_ctrl_tb_top.sv
// Bench: incadc_ctrl_tb_top
// Scoreboard bench. A driver task models a first-order modulator and
// queues the expected samples; a monitor compares each strobed sample.
module incadc_ctrl_tb_top;

    typedef struct {
        int exp_cnt;
        int ideal;
        int bits;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dens = 1'b0;
    logic        res_wide = 1'b0;
    logic        int_clr;
    logic [11:0] smp;
    logic        smp_vld;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    int    last_exp = 0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    incadc_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dens_i     (dens),
        .res_wide_i (res_wide),
        .int_clr_o  (int_clr),
        .smp_o      (smp),
        .smp_vld_o  (smp_vld)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One conversion. Entered at the negedge of a clear cycle.
    task automatic conv(input bit wide, input int level, input bit flip);
        int  n;
        int  bits;
        int  macc;
        int  ones;
        bit  bad_clr;
        bit  bad_vld;
        item_t it;
        bits = wide ? 12 : 8;
        n = 1 << bits;
        macc = 0;
        ones = 0;
        bad_clr = 1'b0;
        bad_vld = 1'b0;
        res_wide = wide;
        dens = 1'b1;          // R6: high during the clear cycle, must be ignored
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int_clr) bad_clr = 1'b1;
            if (smp_vld) bad_vld = 1'b1;
            if (flip && i == 5) res_wide = ~wide;   // R7: change inside the window
            if (i == 100) chk(smp == 12'(last_exp), "R8 sample held", int'(smp), last_exp);
            macc += level;
            if (macc >= 65536) begin
                macc -= 65536;
                dens = 1'b1;
                ones++;
            end else begin
                dens = 1'b0;
            end
        end
        chk(!bad_clr, "R2 clear low for the whole window", int'(bad_clr), 0);
        chk(!bad_vld, "R3 no strobe inside the window", int'(bad_vld), 0);
        it.exp_cnt = (ones >= n) ? n - 1 : ones;
        it.ideal = int'((longint'(level) * n) / 65536);
        it.bits = bits;
        sb_q.push_back(it);
        last_exp = it.exp_cnt;
        @(negedge clk);
        chk(int_clr == 1'b1, "R2 clear after 2^N cycles", int'(int_clr), 1);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: pops the scoreboard on every strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && smp_vld) begin
                item_t it;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected strobe", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    chk(int_clr == 1'b1, "R3 strobe during clear", int'(int_clr), 1);
                    chk(int'(smp) == it.exp_cnt, "R4/R6 exact count (R5 R9 limits)",
                        int'(smp), it.exp_cnt);
                    chk((int'(smp) - it.ideal <= 1) && (it.ideal - int'(smp) <= 1),
                        "R4 within one LSB of level", int'(smp), it.ideal);
                end
            end
        end
    end

    // Driver
    initial begin
        repeat (4) @(negedge clk);
        chk(int_clr == 1'b1, "R1 clear in reset", int'(int_clr), 1);
        chk(smp_vld == 1'b0, "R1 strobe low in reset", int'(smp_vld), 0);
        chk(smp == 12'd0, "R1 sample zero in reset", int'(smp), 0);
        rst_n = 1'b1;
        conv(1'b0, 32768, 1'b0);
        conv(1'b0, 0, 1'b0);          // R9
        conv(1'b0, 65536, 1'b0);      // R5 narrow
        conv(1'b0, 12345, 1'b1);      // R7 narrow window kept
        conv(1'b1, 20000, 1'b0);
        conv(1'b1, 65536, 1'b1);      // R5 wide, R7 wide window kept
        conv(1'b0, 50000, 1'b0);
        @(negedge clk);
        chk(sb_q.size() == 0, "R3 every sample strobed", sb_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule